// File: doc/BRIEF.md
# Armed and Masked Priority Interrupt Controller

This block gathers interrupt requests from a parameterised number of external levels and decides which level, if any, the processor core takes next. It turns a rising edge on an armed level's request line into a sticky pending flag. Of the levels that are pending, armed and not masked, the lowest-numbered one wins. The grant goes out only when the core is at an interruptible point: the boundary strobe is high, or the core is waiting.

Each level has an arm bit and a mask bit. A disarmed level behaves as if its request source were absent: its edges are dropped and any pending flag it held is discarded. A masked level keeps its pending flag but is not granted until the mask is lifted. The highest-numbered level can be built as non-maskable. Privileged configuration writes load the arm and mask registers. A write attempted in user mode changes nothing and produces a one-cycle error pulse. The grant is combinational within the cycle, and the winning level's pending flag drops at the end of that cycle.

Top module: `irqc_top`

## Requirements
- R1: A 0-to-1 transition on `req_i[k]`, seen between one clock sample and the next, sets pending flag k when level k is armed. The flag stays set after the request line falls.
- R2: While level k is disarmed, its request edges are ignored and its pending flag is cleared. Re-arming the level does not bring back a request that arrived or was held while it was disarmed.
- R3: A masked level keeps its pending flag but is never granted. Once the mask bit is cleared, the held request is granted at the next interruptible point.
- R4: When `NMI_EN` is 1, level N-1 is granted whenever it is pending and armed, whatever its mask bit.
- R5: When several eligible levels are pending at once, the lowest index wins and appears on `take_idx_o`.
- R6: `take_o` is high in a cycle only if `boundary_i` or `wait_i` is high in that cycle and at least one level is eligible. If both strobes are low, nothing is granted.
- R7: In a cycle where `take_o` is high, the granted level's pending flag is cleared at the closing clock edge. A new edge on that same level in the same cycle re-sets the flag. `take_idx_o` is 0 whenever `take_o` is low.
- R8: `wake_o` is high exactly when a grant is issued while `wait_i` is high.
- R9: When `cfg_wr_i` and `priv_i` are both high, `cfg_data_i` is loaded into the arm register (`cfg_sel_i`=0) or the mask register (`cfg_sel_i`=1). The new value governs eligibility from the next cycle on.
- R10: When `cfg_wr_i` is high and `priv_i` is low, neither register changes, and `cfg_err_o` is high for exactly the following cycle.
- R11: After reset, all levels are disarmed and unmasked, no flag is pending, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N | Raw request line per level |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the arm register, 1 selects the mask register |
| cfg_data_i | input | N | Configuration write data, one bit per level |
| priv_i | input | 1 | Core is in privileged mode |
| boundary_i | input | 1 | Core is between two instructions |
| wait_i | input | 1 | Core is in the wait state |
| take_o | output | 1 | Take an interrupt this cycle |
| take_idx_o | output | IW | Index of the granted level |
| wake_o | output | 1 | Grant issued while the core waits |
| cfg_err_o | output | 1 | Pulse after a refused user-mode write |

## Verification
The properties assume that the core holds `cfg_sel_i` and `cfg_data_i` steady and meaningful whenever `cfg_wr_i` is high. They also assume the request lines are synchronous to `clk`, so each edge is seen exactly once.

The stimulus changes every input only on the falling clock edge. Random cycles mix privileged and user-mode writes, sparse boundary strobes and waits, and toggling request lines. Directed sequences set up the masked-hold, disarm-discard, non-maskable and tie cases on purpose.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic {
      CFG_ARM  = 1'b0,
      CFG_MASK = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic         sel_i,
   input  logic [N-1:0] data_i,
   input  logic         priv_i,
   output logic [N-1:0] arm_q,
   output logic [N-1:0] mask_q,
   output logic         err_q
);
   import irqc_pkg::*;

   logic do_write;
   logic refused;

   assign do_write = wr_i & priv_i;
   assign refused  = wr_i & ~priv_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q  <= '0;
         mask_q <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= refused;
         if (do_write) begin
            if (cfg_sel_e'(sel_i) == CFG_MASK) mask_q <= data_i;
            else                               arm_q  <= data_i;
         end
      end
   end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] arm_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_q
);
   logic [N-1:0] req_d;
   logic [N-1:0] rise;

   assign rise = req_i & ~req_d;

   generate
      for (genvar k = 0; k < N; k++) begin : g_lvl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_d[k]  <= 1'b0;
               pend_q[k] <= 1'b0;
            end else begin
               req_d[k]  <= req_i[k];
               pend_q[k] <= ((pend_q[k] & ~clr_i[k]) | rise[k]) & arm_i[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o,
   output logic [N-1:0]  onehot_o
);
   always_comb begin
      idx_o    = '0;
      onehot_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            idx_o    = IW'(i);
            onehot_o = N'(1) << i;
         end
      end
   end

   assign any_o = |vec_i;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
   parameter int N      = 8,
   parameter bit NMI_EN = 1'b1,
   localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic          cfg_wr_i,
   input  logic          cfg_sel_i,
   input  logic [N-1:0]  cfg_data_i,
   input  logic          priv_i,
   input  logic          boundary_i,
   input  logic          wait_i,
   output logic          take_o,
   output logic [IW-1:0] take_idx_o,
   output logic          wake_o,
   output logic          cfg_err_o
);
   localparam logic [N-1:0] TOP_BIT = N'(1) << (N - 1);

   generate
      if (N < 2 || N > 64) begin : g_bad_n
         $error("irqc_top: N must lie in 2..64");
      end
   endgenerate

   logic [N-1:0]  arm_q, mask_q, pend_q, eff_mask, elig, win_1h, clr;
   logic          any_elig, at_point;
   logic [IW-1:0] win_idx;

   irqc_cfg #(.N(N)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .sel_i(cfg_sel_i),
      .data_i(cfg_data_i), .priv_i(priv_i),
      .arm_q(arm_q), .mask_q(mask_q), .err_q(cfg_err_o)
   );

   irqc_pend #(.N(N)) u_pend (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .arm_i(arm_q),
      .clr_i(clr), .pend_q(pend_q)
   );

   generate
      if (NMI_EN) begin : g_nmi
         assign eff_mask = mask_q & ~TOP_BIT;
      end else begin : g_all_maskable
         assign eff_mask = mask_q;
      end
   endgenerate

   assign elig = pend_q & arm_q & ~eff_mask;

   irqc_prio #(.N(N), .IW(IW)) u_prio (
      .vec_i(elig), .any_o(any_elig), .idx_o(win_idx), .onehot_o(win_1h)
   );

   assign at_point   = boundary_i | wait_i;
   assign take_o     = at_point & any_elig;
   assign take_idx_o = take_o ? win_idx : '0;
   assign clr        = take_o ? win_1h : '0;
   assign wake_o     = take_o & wait_i;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int N      = 8,
   parameter bit NMI_EN = 1'b1,
   parameter int IW     = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr_i,
   input logic          priv_i,
   input logic          boundary_i,
   input logic          wait_i,
   input logic          take_o,
   input logic [IW-1:0] take_idx_o,
   input logic          wake_o,
   input logic          cfg_err_o,
   input logic [N-1:0]  arm_q,
   input logic [N-1:0]  mask_q,
   input logic [N-1:0]  elig
);
   AST_POINT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (boundary_i || wait_i)); // R6
   AST_ARMED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> arm_q[take_idx_o]); // R2
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (!NMI_EN || take_idx_o != IW'(N - 1))) |-> !mask_q[take_idx_o]); // R3
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ((elig & ((N'(1) << take_idx_o) - N'(1))) == '0)); // R5
   AST_WAKE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (take_o && wait_i)); // R8
   AST_USER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && !priv_i) |=> cfg_err_o); // R10
   AST_USER_NOCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && !priv_i) |=> ($stable(arm_q) && $stable(mask_q))); // R10
   AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !take_o |-> (take_idx_o == '0)); // R7
endmodule

bind irqc_top irqc_chk #(.N(N), .NMI_EN(NMI_EN), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr_i), .priv_i(priv_i),
   .boundary_i(boundary_i), .wait_i(wait_i), .take_o(take_o),
   .take_idx_o(take_idx_o), .wake_o(wake_o), .cfg_err_o(cfg_err_o),
   .arm_q(arm_q), .mask_q(mask_q), .elig(elig)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
   localparam int N   = 8;
   localparam int IW  = 3;
   localparam int TCK = 10;
   localparam logic [N-1:0] NMI_BIT = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          wr = 1'b0, sel = 1'b0, pv = 1'b0, bd = 1'b0, wt = 1'b0;
   logic [N-1:0]  dat = '0;
   logic          take, wake, err;
   logic [IW-1:0] idx;

   int checks = 0;
   int errors = 0;

   logic [N-1:0] m_arm = '0, m_mask = '0, m_pend = '0, m_reqq = '0;
   logic         m_err = 1'b0;

   always #(TCK / 2) clk = ~clk;

   irqc_top #(.N(N), .NMI_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_wr_i(wr), .cfg_sel_i(sel),
      .cfg_data_i(dat), .priv_i(pv), .boundary_i(bd), .wait_i(wt),
      .take_o(take), .take_idx_o(idx), .wake_o(wake), .cfg_err_o(err)
   );

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return 0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] rq, input logic w, input logic s,
                       input logic [N-1:0] d, input logic p, input logic b,
                       input logic t, input string tag);
      logic [N-1:0] elig, rise, clr;
      logic         etake;
      int           eidx;
      @(negedge clk);
      req = rq; wr = w; sel = s; dat = d; pv = p; bd = b; wt = t;
      #1;
      elig  = m_pend & m_arm & ~(m_mask & ~NMI_BIT);
      etake = (b | t) && (elig != '0);
      eidx  = etake ? lowest(elig) : 0;
      check({tag, " take"}, 32'(take), 32'(etake));
      check({tag, " idx R7"}, 32'(idx), 32'(eidx));
      check({tag, " wake R8"}, 32'(wake), 32'(etake & t));
      check({tag, " err R10"}, 32'(err), 32'(m_err));
      rise   = rq & ~m_reqq;
      clr    = etake ? (N'(1) << eidx) : '0;
      m_pend = ((m_pend & ~clr) | rise) & m_arm;
      m_reqq = rq;
      m_err  = w & ~p;
      if (w && p) begin
         if (s) m_mask = d;
         else   m_arm  = d;
      end
   endtask

   task automatic idle(input logic [N-1:0] rq, input logic b, input logic t, input string tag);
      step(rq, 1'b0, 1'b0, '0, 1'b1, b, t, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R11 take", 32'(take), 0);
      check("R11 wake", 32'(wake), 0);
      check("R11 err", 32'(err), 0);
      @(negedge clk) rst_n = 1'b1;

      // R1 / R2: edge on disarmed level is dropped
      idle(8'h01, 1, 0, "R2 disarmed edge");
      idle(8'h00, 1, 0, "R2 disarmed quiet");
      // R9: arm all levels
      step('0, 1, 0, 8'hFF, 1, 0, 0, "R9 arm write");
      idle(8'h00, 1, 0, "R2 no recovery after arm");
      // R1: sticky edge, no point => no grant (R6)
      idle(8'h04, 0, 0, "R1 edge");
      idle(8'h00, 0, 0, "R6 no point");
      idle(8'h00, 1, 0, "R1 grant level 2");
      idle(8'h00, 1, 0, "R7 cleared");
      // R5: tie between 1 and 3
      idle(8'h0A, 0, 0, "R5 edges");
      idle(8'h00, 1, 0, "R5 lowest first");
      idle(8'h00, 1, 0, "R5 second");
      // R3: mask level 0, hold, then unmask
      step('0, 1, 1, 8'h81, 1, 0, 0, "R9 mask write");
      idle(8'h81, 0, 0, "R3 edges on masked");
      idle(8'h00, 1, 0, "R4 nmi despite mask");
      idle(8'h00, 1, 0, "R3 held, no grant");
      step('0, 1, 1, 8'h00, 1, 0, 0, "R3 unmask");
      idle(8'h00, 0, 1, "R3 held taken while waiting R8");
      // R10: user-mode write refused
      step('0, 1, 0, 8'h00, 0, 0, 0, "R10 user write");
      idle(8'h20, 0, 0, "R10 arm kept");
      idle(8'h00, 1, 0, "R10 level 5 still armed");
      // R2: disarm discards pending
      idle(8'h40, 0, 0, "R2 edge level 6");
      step('0, 1, 0, 8'hBF, 1, 0, 0, "R2 disarm 6");
      idle(8'h00, 1, 0, "R2 discarded");
      step('0, 1, 0, 8'hFF, 1, 0, 0, "R2 rearm");
      idle(8'h00, 1, 0, "R2 no return");
      // R7: re-edge on granted level in grant cycle
      idle(8'h02, 0, 0, "R7 edge");
      idle(8'h00, 0, 0, "R7 low");
      idle(8'h02, 1, 0, "R7 grant with new edge");
      idle(8'h00, 1, 0, "R7 re-set taken");

      for (int n = 0; n < 3000; n++) begin
         logic w, p;
         w = ($urandom % 8) == 0;
         p = ($urandom % 4) != 0;
         step(N'($urandom), w, 1'($urandom), N'($urandom), p,
              ($urandom % 4) == 0, ($urandom % 8) == 0, "R5 R6 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end
endmodule